// File: doc/BRIEF.md
# Calendar Real-Time Counter with Periodic Timer and Match Trigger

The block keeps time from a single-cycle enable that pulses at 32768 Hz. The time base is split into three counters: a 16-bit sub-count of 32 kHz ticks, a 16-bit count of two-second units, and a 14-bit day count. When the sub-count rolls over, one two-second unit elapses. When the two-second count passes its last value of a day, the day count advances.

Two sticky event flags come out of the block. The periodic timer flag marks intervals from 1/8 s to 16 s, picked by a 3-bit code. The match flag fires when the combined {two-second, sub-count} value equals a programmable 32-bit compare word. Bit 0 of that comparison can be masked. A small synchronous register port sets the controls. It also preloads the counters from the compare word through load bits that clear themselves, clears each flag through its own write-one bit, and reads back the state. There is no streaming data path, so every pin is plain control or status.

Top module: `rtc_calendar`

## Requirements
- R1: Reset clears all counters, both flags, the compare word and all controls. Each cycle with `tick_32k` high and no load command increments the sub-count by one. With `tick_32k` low, all three counters hold.
- R2: A tick at sub-count 0xFFFF sets the sub-count to 0 and advances the two-second count. If the two-second count was 43199, it becomes 0 and the day count advances instead, and the day count wraps from 0x3FFF to 0.
- R3: Writing the mode register (address 1) with bit 6 set copies compare[31:16] into the two-second count and compare[15:0] into the sub-count. The load takes precedence over a tick in the same cycle, and bit 6 reads back as 0.
- R4: Writing the mode register with bit 7 set copies compare[13:0] into the day count, and bit 7 reads back as 0.
- R5: With the timer enable (mode bit 4) set, a tick that leaves the low 12+code bits of {two-second, sub-count} all zero sets the timer flag. The code is mode bits 2:0, and codes 0 to 7 give intervals of 0.125 s to 16 s.
- R6: With the match enable (mode bit 5) set, a tick that makes {two-second, sub-count} equal the compare word sets the match flag. When mode bit 3 is 1, bit 0 is left out of the comparison; when it is 0, all 32 bits must match.
- R7: Both flags stay set until cleared. Writing the flag register (address 0) with bit 4 set clears the timer flag, and with bit 5 set clears the match flag. A set event in the same cycle as a clear leaves the flag set.
- R8: With an enable bit at 0, the corresponding flag is never set.
- R9: Reads are combinational from `reg_addr`. Address 0 returns the timer flag on bit 6, the match flag on bit 7 and zero elsewhere. Address 1 returns mode bits 5:0. Address 2 returns the compare word. Addresses 3, 4 and 5 return the sub-count, the two-second count and the day count, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at 32768 Hz |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| timer_flag | output | 1 | Sticky periodic timer flag |
| match_flag | output | 1 | Sticky compare match flag |

## Verification
On every cycle, the embedded properties check three things. The counters hold when there is no tick. Each load command copies the compare word into the counters. A flag that is not cleared stays set, and a disabled match source never raises its flag. The bench shows the rest. It checks the exact tick on which each of the eight timer intervals fires, starting just short of each boundary. It exercises the rollover into the next day, the masked and unmasked match, and a clear that lands in the same cycle as a set.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int SUB_W      = 16;
  localparam int SEC2_W     = 16;
  localparam int DAY_W      = 14;
  localparam int SEC2_LAST  = 43199;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 3;
  localparam int MODE_W     = 3;
  localparam int BASE_SHIFT = 12;

  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP   = 3'd2;
  localparam logic [ADDR_W-1:0] A_SUB   = 3'd3;
  localparam logic [ADDR_W-1:0] A_SEC2  = 3'd4;
  localparam logic [ADDR_W-1:0] A_DAY   = 3'd5;

  typedef struct packed {
    logic                  load_hi;
    logic                  load_lo;
    logic                  match_en;
    logic                  timer_en;
    logic                  skip_b0;
    logic [MODE_W-1:0]     period;
  } mode_t;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int SUB_W     = 16,
  parameter int SEC2_W    = 16,
  parameter int DAY_W     = 14,
  parameter int SEC2_LAST = 43199,
  localparam int CNT_W    = SUB_W + SEC2_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_lo,
  input  logic              load_hi,
  input  logic [CNT_W-1:0]  cmp_word,
  output logic [SUB_W-1:0]  sub_cnt,
  output logic [SEC2_W-1:0] sec2_cnt,
  output logic [DAY_W-1:0]  day_cnt,
  output logic              step,
  output logic [CNT_W-1:0]  next_count
);
  logic              sub_wrap, sec2_wrap;
  logic [SUB_W-1:0]  sub_nx;
  logic [SEC2_W-1:0] sec2_nx;

  always_comb begin
    step      = tick && !load_lo && !load_hi;
    sub_wrap  = (sub_cnt == {SUB_W{1'b1}});
    sec2_wrap = (sec2_cnt == SEC2_W'(SEC2_LAST));
    sub_nx    = sub_cnt + SUB_W'(1);
    if (!sub_wrap)      sec2_nx = sec2_cnt;
    else if (sec2_wrap) sec2_nx = '0;
    else                sec2_nx = sec2_cnt + SEC2_W'(1);
    next_count = {sec2_nx, sub_nx};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_cnt  <= '0;
      sec2_cnt <= '0;
      day_cnt  <= '0;
    end else begin
      if (load_lo) begin
        sub_cnt  <= cmp_word[SUB_W-1:0];
        sec2_cnt <= cmp_word[CNT_W-1:SUB_W];
      end else if (step) begin
        sub_cnt  <= sub_nx;
        sec2_cnt <= sec2_nx;
      end
      if (load_hi)
        day_cnt <= cmp_word[DAY_W-1:0];
      else if (step && sub_wrap && sec2_wrap)
        day_cnt <= day_cnt + DAY_W'(1);
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_lo && !load_hi) |=> ($stable(sub_cnt) && $stable(sec2_cnt) && $stable(day_cnt))); // R1
  AST_DAY_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sub_cnt == {SUB_W{1'b1}} && sec2_cnt == SEC2_W'(SEC2_LAST))
      |=> (sub_cnt == '0 && sec2_cnt == '0)); // R2
  AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    load_lo |=> ({sec2_cnt, sub_cnt} == $past(cmp_word))); // R3
  AST_LOAD_HI: assert property (@(posedge clk) disable iff (!rst_n)
    load_hi |=> (day_cnt == $past(cmp_word[DAY_W-1:0]))); // R4
endmodule

// File: rtl/rtc_events.sv
module rtc_events #(
  parameter int CNT_W      = 32,
  parameter int MODE_W     = 3,
  parameter int BASE_SHIFT = 12,
  localparam int N_PERIODS = 1 << MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [CNT_W-1:0]  next_count,
  input  logic [CNT_W-1:0]  cmp_word,
  input  logic [MODE_W-1:0] period,
  input  logic              skip_b0,
  input  logic              timer_en,
  input  logic              match_en,
  input  logic              clr_timer,
  input  logic              clr_match,
  output logic              timer_flag,
  output logic              match_flag
);
  logic [CNT_W-1:0] period_mask [N_PERIODS];
  logic [CNT_W-1:0] cmp_mask;
  logic             timer_hit, match_hit;

  for (genvar m = 0; m < N_PERIODS; m++) begin : g_period
    assign period_mask[m] = (CNT_W'(1) << (BASE_SHIFT + m)) - CNT_W'(1);
  end

  always_comb begin
    cmp_mask  = {{(CNT_W-1){1'b1}}, !skip_b0};
    timer_hit = step && timer_en && ((next_count & period_mask[period]) == '0);
    match_hit = step && match_en && (((next_count ^ cmp_word) & cmp_mask) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_flag <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      if (timer_hit)      timer_flag <= 1'b1;
      else if (clr_timer) timer_flag <= 1'b0;
      if (match_hit)      match_flag <= 1'b1;
      else if (clr_match) match_flag <= 1'b0;
    end
  end

  AST_TIMER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_flag && !clr_timer) |=> timer_flag); // R7
  AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !clr_match) |=> match_flag); // R7
  AST_MATCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_en && !match_flag) |=> !match_flag); // R8
  AST_TIMER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_en && !timer_flag) |=> !timer_flag); // R8
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_cal_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int SUB_W   = 16,
  parameter int SEC2_W  = 16,
  parameter int DAY_W   = 14,
  localparam int CNT_W  = SUB_W + SEC2_W,
  localparam int MODE_BITS = $bits(mode_t)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [SUB_W-1:0]  sub_cnt,
  input  logic [SEC2_W-1:0] sec2_cnt,
  input  logic [DAY_W-1:0]  day_cnt,
  input  logic              timer_flag,
  input  logic              match_flag,
  output mode_t             mode,
  output logic [CNT_W-1:0]  cmp_word,
  output logic              load_lo,
  output logic              load_hi,
  output logic              clr_timer,
  output logic              clr_match
);
  mode_t mode_q;
  mode_t mode_w;
  logic  wr_mode, wr_flags;

  always_comb begin
    mode_w    = mode_t'(reg_wdata[MODE_BITS-1:0]);
    wr_mode   = reg_wr && (reg_addr == A_MODE);
    wr_flags  = reg_wr && (reg_addr == A_FLAGS);
    load_lo   = wr_mode && mode_w.load_lo;
    load_hi   = wr_mode && mode_w.load_hi;
    clr_timer = wr_flags && reg_wdata[4];
    clr_match = wr_flags && reg_wdata[5];
    mode      = mode_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      cmp_word <= '0;
    end else begin
      if (wr_mode) begin
        mode_q         <= mode_w;
        mode_q.load_lo <= 1'b0;
        mode_q.load_hi <= 1'b0;
      end
      if (reg_wr && reg_addr == A_CMP)
        cmp_word <= reg_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_FLAGS: reg_rdata = DATA_W'({match_flag, timer_flag, 6'b0});
      A_MODE:  reg_rdata = DATA_W'(mode_q);
      A_CMP:   reg_rdata = DATA_W'(cmp_word);
      A_SUB:   reg_rdata = DATA_W'(sub_cnt);
      A_SEC2:  reg_rdata = DATA_W'(sec2_cnt);
      A_DAY:   reg_rdata = DATA_W'(day_cnt);
      default: reg_rdata = '0;
    endcase
  end

  AST_LOAD_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (!mode_q.load_lo && !mode_q.load_hi)); // R3
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int P_SUB_W     = SUB_W,
  parameter int P_SEC2_W    = SEC2_W,
  parameter int P_DAY_W     = DAY_W,
  parameter int P_SEC2_LAST = SEC2_LAST,
  parameter int P_DATA_W    = DATA_W,
  parameter int P_ADDR_W    = ADDR_W,
  localparam int CNT_W      = P_SUB_W + P_SEC2_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_32k,
  input  logic                reg_wr,
  input  logic [P_ADDR_W-1:0] reg_addr,
  input  logic [P_DATA_W-1:0] reg_wdata,
  output logic [P_DATA_W-1:0] reg_rdata,
  output logic                timer_flag,
  output logic                match_flag
);
  mode_t                mode;
  logic [CNT_W-1:0]     cmp_word, next_count;
  logic [P_SUB_W-1:0]   sub_cnt;
  logic [P_SEC2_W-1:0]  sec2_cnt;
  logic [P_DAY_W-1:0]   day_cnt;
  logic                 load_lo, load_hi, clr_timer, clr_match, step;

  rtc_regs #(
    .DATA_W(P_DATA_W), .ADDR_W(P_ADDR_W),
    .SUB_W(P_SUB_W), .SEC2_W(P_SEC2_W), .DAY_W(P_DAY_W)
  ) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .sub_cnt, .sec2_cnt, .day_cnt, .timer_flag, .match_flag,
    .mode, .cmp_word, .load_lo, .load_hi, .clr_timer, .clr_match
  );

  rtc_timebase #(
    .SUB_W(P_SUB_W), .SEC2_W(P_SEC2_W), .DAY_W(P_DAY_W), .SEC2_LAST(P_SEC2_LAST)
  ) u_timebase (
    .clk, .rst_n, .tick(tick_32k), .load_lo, .load_hi, .cmp_word,
    .sub_cnt, .sec2_cnt, .day_cnt, .step, .next_count
  );

  rtc_events #(
    .CNT_W(CNT_W), .MODE_W(MODE_W), .BASE_SHIFT(BASE_SHIFT)
  ) u_events (
    .clk, .rst_n, .step, .next_count, .cmp_word,
    .period(mode.period), .skip_b0(mode.skip_b0),
    .timer_en(mode.timer_en), .match_en(mode.match_en),
    .clr_timer, .clr_match, .timer_flag, .match_flag
  );

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode.match_en && next_count == cmp_word) |=> match_flag); // R7
endmodule

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  period;
    logic [31:0] start;
    logic [7:0]  n;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 32'h0000_1FFD, 8'd3},
    '{3'd1, 32'h0000_3FFF, 8'd1},
    '{3'd2, 32'h0000_7FFC, 8'd4},
    '{3'd3, 32'h0000_FFFE, 8'd2},
    '{3'd4, 32'h0002_FFFB, 8'd5},
    '{3'd5, 32'h0003_FFFD, 8'd3},
    '{3'd6, 32'h000B_FFFE, 8'd2},
    '{3'd7, 32'h0007_FFFA, 8'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_32k = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        timer_flag, match_flag;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar u_rtc_calendar (
    .clk, .rst_n, .tick_32k, .reg_wr, .reg_addr, .reg_wdata,
    .reg_rdata, .timer_flag, .match_flag
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick_32k = 1'b1;
    repeat (n) @(negedge clk);
    tick_32k = 1'b0;
  endtask

  task automatic chk_cnt(string req, logic [31:0] s2, logic [31:0] sb, logic [31:0] dy);
    logic [31:0] v;
    rd(3'd3, v); check(req, v, sb);
    rd(3'd4, v); check(req, v, s2);
    rd(3'd5, v); check(req, v, dy);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_cnt("R1 reset", 0, 0, 0);
    rd(3'd0, v); check("R1 reset flags", v, 0);
    rd(3'd1, v); check("R1 reset mode", v, 0);
    // R1 counting and holding
    ticks(5);
    chk_cnt("R1 count", 0, 5, 0);
    repeat (4) @(negedge clk);
    rd(3'd3, v); check("R1 hold", v, 5);
    // R2 day rollover and day wrap, R4 day load
    wr(3'd2, 32'h0000_3FFF);
    wr(3'd1, 32'h80);
    wr(3'd2, {16'd43199, 16'hFFFF});
    wr(3'd1, 32'h40);
    chk_cnt("R4 load", 43199, 32'hFFFF, 32'h3FFF);
    rd(3'd1, v); check("R3 R4 self clear", v, 0);
    ticks(1);
    chk_cnt("R2 day wrap", 0, 0, 0);
    wr(3'd2, 32'h0005_FFFF);
    wr(3'd1, 32'h40);
    ticks(1);
    chk_cnt("R2 sec2 carry", 6, 0, 0);
    // R3 load beats a coincident tick
    wr(3'd2, 32'h0000_0103);
    @(negedge clk);
    tick_32k = 1'b1; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h40;
    @(negedge clk);
    tick_32k = 1'b0; reg_wr = 1'b0;
    chk_cnt("R3 load over tick", 0, 32'h103, 0);
    // R6 exact match
    wr(3'd2, 32'h0000_0105);
    wr(3'd1, 32'h20);
    ticks(1);
    check("R6 before match", match_flag, 0);
    ticks(1);
    check("R6 match", match_flag, 1);
    ticks(2);
    check("R7 sticky", match_flag, 1);
    wr(3'd0, 32'h20);
    check("R7 clear", match_flag, 0);
    // R6 masked bit 0
    wr(3'd2, 32'h0000_0109);
    wr(3'd1, 32'h28);
    ticks(1);
    check("R6 masked match", match_flag, 1);
    wr(3'd0, 32'h20);
    // R6 full compare rejects a bit-0 difference
    wr(3'd2, 32'h0000_010B);
    wr(3'd1, 32'h20);
    ticks(2);
    check("R6 unmasked miss", match_flag, 0);
    ticks(1);
    check("R6 unmasked hit", match_flag, 1);
    wr(3'd0, 32'h20);
    // R7 set wins over clear in the same cycle
    wr(3'd2, 32'h0000_010C);
    @(negedge clk);
    tick_32k = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h20;
    @(negedge clk);
    tick_32k = 1'b0; reg_wr = 1'b0;
    check("R7 set wins", match_flag, 1);
    wr(3'd0, 32'h20);
    // R8 disabled match source
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h0000_010E);
    ticks(2);
    check("R8 match disabled", match_flag, 0);
    // R9 register readback
    wr(3'd1, 32'h2D);
    rd(3'd1, v); check("R9 mode readback", v, 32'h2D);
    rd(3'd2, v); check("R9 compare readback", v, 32'h0000_010E);
    rd(3'd7, v); check("R9 unmapped", v, 0);
    ticks(1);
    rd(3'd0, v); check("R9 flag reg layout", v, 32'h80);
    wr(3'd0, 32'hFF);
    rd(3'd0, v); check("R7 clear both", v, 0);
    // R8 timer disabled across an interval boundary
    wr(3'd2, 32'h0000_0FFF);
    wr(3'd1, 32'h40);
    ticks(1);
    check("R8 timer disabled", timer_flag, 0);
    // R5 timer intervals, one vector per code
    foreach (VECS[i]) begin
      wr(3'd2, VECS[i].start);
      wr(3'd1, 32'h50 | 32'(VECS[i].period));
      wr(3'd0, 32'h10);
      if (VECS[i].n > 1) begin
        ticks(int'(VECS[i].n) - 1);
        check("R5 early", timer_flag, 0);
      end
      ticks(1);
      check("R5 interval", timer_flag, 1);
      v = VECS[i].start + 32'(VECS[i].n);
      chk_cnt("R5 count", {16'b0, v[31:16]}, {16'b0, v[15:0]}, 0);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule